// File: doc/BRIEF.md
# I2C Acknowledge-Phase Controller

This block runs the ninth clock of an I2C byte transfer. It counts SCL falling-edge strobes from the start of a frame. When the eighth bit of a byte ends, it decides whether an acknowledge clock follows, using a control bit that enables or suppresses that clock. If the clock follows, the block raises a request to the SCL generator.

During the acknowledge clock the block acts in one of two ways:
- When the local side received the byte, it pulls SDA low or leaves it released, according to the programmed acknowledge value. While an address is being received, and the programmed value asks for an acknowledge, the address-match result decides instead.
- When the local side transmitted the byte, it leaves SDA released and stores the level it samples on the ninth rising edge as the acknowledge status.

A one-cycle byte-done pulse marks the end of every byte. The control inputs are latched at the falling edge that ends the eighth bit and hold for the whole acknowledge clock. START/STOP detection, address comparison and SCL generation are handled elsewhere. A frame-start strobe from the START detector realigns the bit count.

Top module: `i2c_ack_phase_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sda_oe`=0, `ninth_clk_req`=0, `byte_done`=0 and `ack_status`=1.
- R2: With `ack_clk_en`=1, `ninth_clk_req` rises in the cycle after the eighth `scl_fall` strobe that follows `frame_start` or the previous byte. It stays high until the cycle after the next `scl_fall`, and is low after only seven falls.
- R3: With `ack_clk_en`=0 at the eighth fall, `ninth_clk_req` and `sda_oe` stay 0 and `byte_done` pulses in the next cycle. The following byte is again counted from zero.
- R4: Receiving (`rx_mode`=1), outside the address phase, with `ack_val`=0 (return mode): `sda_oe`=1 (SDA pulled low) from the cycle after the eighth fall until the cycle after the ninth fall.
- R5: Receiving with `ack_val`=1 (non-return mode), `sda_oe` stays 0 through the ninth clock, in the address phase as well.
- R6: Receiving in the address phase (`addr_phase`=1) with `ack_val`=0, `sda_oe` during the ninth clock equals `addr_match`.
- R7: Transmitting (`rx_mode`=0), `sda_oe` stays 0 and `sda_in` sampled on the ninth `scl_rise` is stored in `ack_status` (0 = acknowledged), held until the next capture. A received byte leaves `ack_status` unchanged.
- R8: `byte_done` is a single-cycle pulse in the cycle after the ninth `scl_fall`, with `sda_oe` and `ninth_clk_req` back at 0 in that same cycle.
- R9: `frame_start` clears the bit count and abandons a pending ninth clock (`ninth_clk_req` and `sda_oe` to 0) without a `byte_done` pulse.
- R10: `ack_clk_en`, `ack_val`, `rx_mode`, `addr_phase` and `addr_match` are sampled at the eighth fall. Changing them during the ninth clock does not change `sda_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_clk_en | input | 1 | 1 = produce an acknowledge clock after each byte |
| ack_val | input | 1 | 0 = return acknowledge (pull low), 1 = non-return |
| rx_mode | input | 1 | 1 = local side receives the byte, 0 = transmits |
| addr_phase | input | 1 | 1 = current byte is an address byte |
| addr_match | input | 1 | Address comparator result for the current byte |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| frame_start | input | 1 | One-cycle strobe after a START condition |
| sda_in | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| ninth_clk_req | output | 1 | Request to the SCL generator for the ninth clock |
| ack_status | output | 1 | Captured acknowledge, 0 = ACK, 1 = NACK |
| byte_done | output | 1 | One-cycle pulse at the end of each byte |

## Verification
A miscounted bit counter shows up at the ports one cycle after the suspect fall. `ninth_clk_req` rises after the seventh or ninth fall instead of the eighth, and the bench checks both neighbours. A wrong acknowledge decision or a missed latch of the control inputs shows on `sda_oe` in the first cycle of the ninth clock, or while inputs are changed mid-clock. A state machine stuck in the acknowledge phase shows as a missing `byte_done` one cycle after the ninth fall, or as a missing abort after `frame_start`.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_ACK  = 1'b1
  } ack_phase_e;

  // Decide whether the local receiver pulls SDA low in the ninth clock.
  function automatic logic ack_pull_low(input logic rx,
                                        input logic addr,
                                        input logic match,
                                        input logic val);
    logic pull;
    if (!rx)       pull = 1'b0;  // transmitter always releases
    else if (val)  pull = 1'b0;  // non-return mode
    else if (addr) pull = match; // address byte: match result decides
    else           pull = 1'b1;  // return mode
    return pull;
  endfunction

endpackage

// File: rtl/i2c_ack_bitcnt.sv
module i2c_ack_bitcnt #(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic scl_fall,
  input  logic in_data,
  output logic last_fall
);
  localparam int CNT_W = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_BYTE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_fall = in_data && scl_fall && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      cnt_q <= '0;
    end else if (in_data && scl_fall) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_ack_policy.sv
module i2c_ack_policy
  import i2c_ack_pkg::*;
(
  input  logic rx_mode,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic ack_val,
  output logic pull_low
);
  always_comb begin
    pull_low = ack_pull_low(rx_mode, addr_phase, addr_match, ack_val);
  end
endmodule

// File: rtl/i2c_ack_sequencer.sv
module i2c_ack_sequencer
  import i2c_ack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic last_fall,
  input  logic ack_clk_en,
  input  logic pull_low,
  input  logic rx_mode,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  output logic in_data,
  output logic sda_oe,
  output logic ninth_clk_req,
  output logic ack_status,
  output logic byte_done
);
  ack_phase_e phase_q;
  logic       tx_q;

  assign in_data = (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_DATA;
      tx_q          <= 1'b0;
      sda_oe        <= 1'b0;
      ninth_clk_req <= 1'b0;
      ack_status    <= 1'b1;
      byte_done     <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (frame_start) begin
        phase_q       <= PH_DATA;
        sda_oe        <= 1'b0;
        ninth_clk_req <= 1'b0;
      end else if (phase_q == PH_DATA) begin
        if (last_fall) begin
          if (ack_clk_en) begin
            phase_q       <= PH_ACK;
            ninth_clk_req <= 1'b1;
            sda_oe        <= pull_low;
            tx_q          <= !rx_mode;
          end else begin
            byte_done <= 1'b1;
          end
        end
      end else begin
        if (scl_fall) begin
          phase_q       <= PH_DATA;
          sda_oe        <= 1'b0;
          ninth_clk_req <= 1'b0;
          byte_done     <= 1'b1;
        end else if (scl_rise && tx_q) begin
          ack_status <= sda_in;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ack_phase_ctrl.sv
module i2c_ack_phase_ctrl #(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_clk_en,
  input  logic ack_val,
  input  logic rx_mode,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic frame_start,
  input  logic sda_in,
  output logic sda_oe,
  output logic ninth_clk_req,
  output logic ack_status,
  output logic byte_done
);
  logic in_data;
  logic last_fall;
  logic pull_low;

  i2c_ack_bitcnt #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .scl_fall    (scl_fall),
    .in_data     (in_data),
    .last_fall   (last_fall)
  );

  i2c_ack_policy u_pol (
    .rx_mode    (rx_mode),
    .addr_phase (addr_phase),
    .addr_match (addr_match),
    .ack_val    (ack_val),
    .pull_low   (pull_low)
  );

  i2c_ack_sequencer u_seq (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .last_fall     (last_fall),
    .ack_clk_en    (ack_clk_en),
    .pull_low      (pull_low),
    .rx_mode       (rx_mode),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .sda_in        (sda_in),
    .in_data       (in_data),
    .sda_oe        (sda_oe),
    .ninth_clk_req (ninth_clk_req),
    .ack_status    (ack_status),
    .byte_done     (byte_done)
  );
endmodule

// File: rtl/i2c_ack_phase_chk.sv
module i2c_ack_phase_chk (
  input logic clk,
  input logic rst,
  input logic scl_rise,
  input logic scl_fall,
  input logic frame_start,
  input logic sda_oe,
  input logic ninth_clk_req,
  input logic ack_status,
  input logic byte_done
);
  // R4: SDA is only pulled low inside a requested ninth clock
  assert_oe_in_ninth_R4: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> ninth_clk_req);

  // R8: byte-done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);

  // R8: the ninth fall ends the clock and signals byte completion
  assert_ninth_end_R8: assert property (@(posedge clk) disable iff (rst)
    (ninth_clk_req && scl_fall && !frame_start) |=> (byte_done && !ninth_clk_req && !sda_oe));

  // R7: the acknowledge status moves only on a rising strobe inside the ninth clock
  assert_status_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(ninth_clk_req && scl_rise) |=> $stable(ack_status));

  // R10: the SDA drive is frozen for the whole ninth clock
  assert_oe_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (ninth_clk_req && !scl_fall && !frame_start) |=> $stable(sda_oe));

  // R9: a frame start leaves no ninth clock pending and no byte done
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!ninth_clk_req && !sda_oe && !byte_done));
endmodule

bind i2c_ack_phase_ctrl i2c_ack_phase_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_rise      (scl_rise),
  .scl_fall      (scl_fall),
  .frame_start   (frame_start),
  .sda_oe        (sda_oe),
  .ninth_clk_req (ninth_clk_req),
  .ack_status    (ack_status),
  .byte_done     (byte_done)
);

// File: tb/i2c_ack_phase_ctrl_test.sv
module i2c_ack_phase_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_clk_en = 1'b0, ack_val = 1'b0, rx_mode = 1'b0;
  logic addr_phase = 1'b0, addr_match = 1'b0;
  logic scl_rise = 1'b0, scl_fall = 1'b0, frame_start = 1'b0, sda_in = 1'b1;
  logic sda_oe, ninth_clk_req, ack_status, byte_done;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ack_phase_ctrl uut (
    .clk(clk), .rst(rst), .ack_clk_en(ack_clk_en), .ack_val(ack_val),
    .rx_mode(rx_mode), .addr_phase(addr_phase), .addr_match(addr_match),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .frame_start(frame_start),
    .sda_in(sda_in), .sda_oe(sda_oe), .ninth_clk_req(ninth_clk_req),
    .ack_status(ack_status), .byte_done(byte_done)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a negedge; drives strobes for one cycle, returns at the next negedge.
  task automatic strobe(input logic r, input logic f, input logic s);
    scl_rise = r; scl_fall = f; frame_start = s;
    @(posedge clk);
    @(negedge clk);
    scl_rise = 1'b0; scl_fall = 1'b0; frame_start = 1'b0;
  endtask

  task automatic data_bits(input int n);
    for (int i = 0; i < n; i++) begin
      strobe(1'b1, 1'b0, 1'b0);
      strobe(1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic setup(input logic en, input logic val, input logic rx,
                       input logic ad, input logic m);
    ack_clk_en = en; ack_val = val; rx_mode = rx; addr_phase = ad; addr_match = m;
    strobe(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    check("R1 sda_oe", sda_oe, 1'b0);
    check("R1 ninth_clk_req", ninth_clk_req, 1'b0);
    check("R1 byte_done", byte_done, 1'b0);
    check("R1 ack_status", ack_status, 1'b1);
  endtask

  task automatic t_rx_data_ack;
    setup(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    data_bits(7);
    check("R2 no req after seven", ninth_clk_req, 1'b0);
    data_bits(1);
    check("R2 req after eighth", ninth_clk_req, 1'b1);
    check("R4 pull low", sda_oe, 1'b1);
    ack_val = 1'b1; rx_mode = 1'b0; sda_in = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    check("R10 drive frozen", sda_oe, 1'b1);
    check("R7 rx leaves status", ack_status, 1'b1);
    check("R2 req held", ninth_clk_req, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    check("R8 byte_done", byte_done, 1'b1);
    check("R8 released", sda_oe, 1'b0);
    check("R8 req dropped", ninth_clk_req, 1'b0);
    @(negedge clk);
    check("R8 single pulse", byte_done, 1'b0);
    sda_in = 1'b1;
  endtask

  task automatic t_rx_nack;
    setup(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    data_bits(8);
    check("R5 req", ninth_clk_req, 1'b1);
    check("R5 released", sda_oe, 1'b0);
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b1, 1'b0);
    check("R5 done", byte_done, 1'b1);
  endtask

  task automatic t_addr(input logic val, input logic m, input logic exp);
    setup(1'b1, val, 1'b1, 1'b1, m);
    data_bits(8);
    check(val ? "R5 addr non-return" : "R6 addr match drive", sda_oe, exp);
    addr_match = !m;
    strobe(1'b1, 1'b0, 1'b0);
    check("R10 match change ignored", sda_oe, exp);
    strobe(1'b0, 1'b1, 1'b0);
    check("R8 addr done", byte_done, 1'b1);
  endtask

  task automatic t_tx(input logic lvl);
    setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    data_bits(8);
    check("R7 tx releases", sda_oe, 1'b0);
    sda_in = lvl;
    strobe(1'b1, 1'b0, 1'b0);
    sda_in = !lvl;
    check("R7 captured", ack_status, lvl);
    strobe(1'b0, 1'b1, 1'b0);
    check("R7 held after fall", ack_status, lvl);
    check("R8 tx done", byte_done, 1'b1);
    sda_in = 1'b1;
  endtask

  task automatic t_no_ack_clk;
    setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    data_bits(8);
    check("R3 done after eighth", byte_done, 1'b1);
    check("R3 no req", ninth_clk_req, 1'b0);
    check("R3 no drive", sda_oe, 1'b0);
    @(negedge clk);
    check("R3 pulse ends", byte_done, 1'b0);
    data_bits(7);
    check("R3 recount no early done", byte_done, 1'b0);
    data_bits(1);
    check("R3 second byte done", byte_done, 1'b1);
  endtask

  task automatic t_abort;
    setup(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    data_bits(8);
    check("R9 pre abort req", ninth_clk_req, 1'b1);
    strobe(1'b0, 1'b0, 1'b1);
    check("R9 req cleared", ninth_clk_req, 1'b0);
    check("R9 drive cleared", sda_oe, 1'b0);
    check("R9 no done", byte_done, 1'b0);
    data_bits(5);
    strobe(1'b0, 1'b0, 1'b1);
    data_bits(7);
    check("R9 count cleared", ninth_clk_req, 1'b0);
    data_bits(1);
    check("R9 fresh byte req", ninth_clk_req, 1'b1);
    strobe(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_data_ack();
    t_rx_nack();
    t_addr(1'b0, 1'b1, 1'b1);
    t_addr(1'b0, 1'b0, 1'b0);
    t_addr(1'b1, 1'b1, 1'b0);
    t_tx(1'b0);
    t_tx(1'b1);
    t_no_ack_clk();
    t_abort();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule